// File: doc/BRIEF.md
# Paired Gather Load Combiner

This block runs one indirect vector gather. The gather collects eight 64-bit elements from arbitrary byte addresses into one 512-bit destination vector. A start pulse delivers eight element addresses and a per-lane enable mask. The block then issues line reads on two parallel cache read ports. Each read returns one naturally aligned 128-byte block. Each 64-bit word is placed into the lane that asked for it.

Lanes are grouped into fixed even/odd partners: (0,1), (2,3), (4,5) and (6,7). When both partners are enabled and their addresses lie in the same 128-byte block, one read serves both. In the best case a gather therefore needs four reads instead of eight. A disabled lane produces no read and returns zero. A lane whose address is not 8-byte aligned is treated the same way and also raises an error flag.

The cache behind the ports is treated as fixed-latency memory. Each read carries a lane tag, and the matching response echoes that tag back. A count of the reads issued is reported, so the saving from pairing can be seen at the ports.

Top module: `gather_pair_combiner`

## Requirements
- R1: When both lanes of an even/odd partner pair (2k, 2k+1) are enabled, aligned, and have equal address bits [63:7], the pair is served by exactly one read whose tag has both lane bits set. A gather in which all four pairs meet this rule uses exactly 4 reads.
- R2: An enabled, aligned pair whose addresses lie in different 128-byte blocks uses two reads, one per lane. Reads are issued lowest pending lane first, at most two per cycle. Port 1 carries a read only in a cycle where port 0 also carries one.
- R3: A lane whose enable bit is 0 issues no read and reads back as zero in the destination. A pair with exactly one usable lane costs one read.
- R4: Address bits [6:3] select which 64-bit word of the returned block goes into the lane. Word w sits at bits [64w+63:64w] of the port's response data.
- R5: A lane whose address has bits [2:0] not equal to zero is handled as disabled: no read, zero data. It also sets `misalign_err`, which holds until the next accepted start.
- R6: `done` is high for exactly one cycle, one cycle after the last response has been written. `dest` and `flow_count` then hold their values until the next accepted start.
- R7: `busy` rises the cycle after an accepted start and falls in the cycle `done` is high. A start seen while `busy` is high is ignored. No read is issued while `busy` is low.
- R8: `flow_count` equals the number of reads issued by the current gather.
- R9: Every read address has bits [6:0] equal to zero.
- R10: After reset, `busy`, `done`, `flow_count`, `misalign_err` and `dest` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a gather (ignored while busy) |
| elem_addr | input | 8x64 | Byte address per lane |
| lane_en | input | 8 | Per-lane enable |
| busy | output | 1 | Gather in progress |
| done | output | 1 | One-cycle completion pulse |
| misalign_err | output | 1 | Some lane was not 8-byte aligned |
| flow_count | output | 4 | Reads used by the gather |
| dest | output | 512 | Gathered vector, lane i at bits [64i+63:64i] |
| rd_valid | output | 2 | Read request per port |
| rd_addr | output | 2x64 | 128-byte aligned block address per port |
| rd_tag | output | 2x8 | Lanes served by the read |
| rsp_valid | input | 2 | Response per port |
| rsp_tag | input | 2x8 | Echoed lane tag |
| rsp_data | input | 2x16x64 | Returned 128-byte block |

## Verification
If the pending or outstanding lane state is wrong, the read count or the request pattern is the first thing to go wrong. This shows up at the ports within two cycles of start, as a missing or extra read or a port 1 read without a port 0 read. A wrong final `flow_count` follows at completion. A wrong word select or a wrong tag decode corrupts a lane of `dest`, which is compared against memory contents computed in the bench when `done` is seen. A wrong outstanding mask makes `done` either fire before all data is in, which leaves a stale or zero lane, or never fire, which the bench counts as a failure.

// File: rtl/gpc_pkg.sv
// Package: default geometry shared by the gather combiner modules.
// Assumes elements and blocks are powers of two in bytes.
package gpc_pkg;
    localparam int GPC_LANES       = 8;
    localparam int GPC_PORTS       = 2;
    localparam int GPC_ADDR_W      = 64;
    localparam int GPC_ELEM_W      = 64;
    localparam int GPC_BLOCK_BYTES = 128;
endpackage

// File: rtl/gpc_pair_match.sv
// Module: decides, for each even/odd lane pair, whether both lanes share
// one aligned block. Assumes LANES is even; purely combinational.
module gpc_pair_match #(
    parameter int LANES = gpc_pkg::GPC_LANES,
    parameter int BLK_W = 57
) (
    input  logic [LANES-1:0][BLK_W-1:0] blk,
    output logic [LANES/2-1:0]          same_blk
);
    localparam int PAIRS = LANES / 2;

    for (genvar k = 0; k < PAIRS; k++) begin : g_pair
        // compare block indices of partner lanes
        assign same_blk[k] = (blk[2*k] == blk[2*k+1]);
    end
endmodule

// File: rtl/gpc_flow_pick.sv
// Module: chooses up to NPORT reads for this cycle from the pending lanes,
// lowest lane first; an even lane takes its odd partner along when both are
// pending and share a block. Assumes LANES is even; combinational.
module gpc_flow_pick #(
    parameter int LANES  = gpc_pkg::GPC_LANES,
    parameter int NPORT  = gpc_pkg::GPC_PORTS,
    parameter int ADDR_W = gpc_pkg::GPC_ADDR_W,
    parameter int OFF_W  = 7
) (
    input  logic [LANES-1:0]                    pend,
    input  logic [LANES/2-1:0]                  same_blk,
    input  logic [LANES-1:0][ADDR_W-OFF_W-1:0]  blk,
    output logic [NPORT-1:0]                    f_valid,
    output logic [NPORT-1:0][LANES-1:0]         f_mask,
    output logic [NPORT-1:0][ADDR_W-1:0]        f_addr
);
    localparam int IDX_W = $clog2(LANES);

    logic [LANES-1:0] rem;
    logic [IDX_W-1:0] idx;
    logic             found;

    // walk the ports, each taking the lowest remaining lane (and partner)
    always_comb begin
        rem     = pend;
        f_valid = '0;
        f_mask  = '0;
        f_addr  = '0;
        idx     = '0;
        found   = 1'b0;
        for (int p = 0; p < NPORT; p++) begin
            found = 1'b0;
            idx   = '0;
            for (int i = LANES - 1; i >= 0; i--) begin
                if (rem[i]) begin
                    found = 1'b1;
                    idx   = IDX_W'(i);
                end
            end
            if (found) begin
                f_valid[p]      = 1'b1;
                f_mask[p][idx]  = 1'b1;
                if (!idx[0] && same_blk[idx >> 1] && rem[idx + IDX_W'(1)])
                    f_mask[p][idx + IDX_W'(1)] = 1'b1;
                f_addr[p] = {blk[idx], OFF_W'(0)};
                rem       = rem & ~f_mask[p];
            end
        end
    end
endmodule

// File: rtl/gpc_lane_write.sv
// Module: routes returned block words into lanes. A lane is written when a
// valid response on any port carries its tag bit; the word is picked by the
// lane's stored word index. Assumes at most one port tags a lane per cycle.
module gpc_lane_write #(
    parameter int LANES  = gpc_pkg::GPC_LANES,
    parameter int NPORT  = gpc_pkg::GPC_PORTS,
    parameter int ELEM_W = gpc_pkg::GPC_ELEM_W,
    parameter int WORDS  = 16,
    parameter int WSEL_W = 4
) (
    input  logic [LANES-1:0][WSEL_W-1:0]            wsel,
    input  logic [NPORT-1:0]                        rsp_valid,
    input  logic [NPORT-1:0][LANES-1:0]             rsp_tag,
    input  logic [NPORT-1:0][WORDS-1:0][ELEM_W-1:0] rsp_data,
    output logic [LANES-1:0]                        wr_en,
    output logic [LANES-1:0][ELEM_W-1:0]            wr_data
);
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        // select the port serving this lane and extract its word
        always_comb begin
            wr_en[i]   = 1'b0;
            wr_data[i] = '0;
            for (int p = 0; p < NPORT; p++) begin
                if (rsp_valid[p] && rsp_tag[p][i]) begin
                    wr_en[i]   = 1'b1;
                    wr_data[i] = rsp_data[p][wsel[i]];
                end
            end
        end
    end
endmodule

// File: rtl/gather_pair_combiner.sv
// Module: top of the paired gather combiner. Latches a gather on start,
// issues block reads via gpc_flow_pick, collects tagged responses and pulses
// done one cycle after the last lane is written. Assumes the memory answers
// every read exactly once with its tag, after at least one cycle.
module gather_pair_combiner #(
    parameter int LANES       = gpc_pkg::GPC_LANES,
    parameter int NPORT       = gpc_pkg::GPC_PORTS,
    parameter int ADDR_W      = gpc_pkg::GPC_ADDR_W,
    parameter int ELEM_W      = gpc_pkg::GPC_ELEM_W,
    parameter int BLOCK_BYTES = gpc_pkg::GPC_BLOCK_BYTES,
    localparam int OFF_W  = $clog2(BLOCK_BYTES),
    localparam int EB_W   = $clog2(ELEM_W / 8),
    localparam int WORDS  = BLOCK_BYTES * 8 / ELEM_W,
    localparam int WSEL_W = OFF_W - EB_W,
    localparam int BLK_W  = ADDR_W - OFF_W,
    localparam int FC_W   = $clog2(LANES + 1)
) (
    input  logic                                    clk,
    input  logic                                    rst_n,
    input  logic                                    start,
    input  logic [LANES-1:0][ADDR_W-1:0]            elem_addr,
    input  logic [LANES-1:0]                        lane_en,
    output logic                                    busy,
    output logic                                    done,
    output logic                                    misalign_err,
    output logic [FC_W-1:0]                         flow_count,
    output logic [LANES*ELEM_W-1:0]                 dest,
    output logic [NPORT-1:0]                        rd_valid,
    output logic [NPORT-1:0][ADDR_W-1:0]            rd_addr,
    output logic [NPORT-1:0][LANES-1:0]             rd_tag,
    input  logic [NPORT-1:0]                        rsp_valid,
    input  logic [NPORT-1:0][LANES-1:0]             rsp_tag,
    input  logic [NPORT-1:0][WORDS-1:0][ELEM_W-1:0] rsp_data
);
    logic [LANES-1:0][BLK_W-1:0]  blk_q;
    logic [LANES-1:0][WSEL_W-1:0] wsel_q;
    logic [LANES-1:0]             pend_q;
    logic [LANES-1:0]             wait_q;
    logic [LANES-1:0][ELEM_W-1:0] dest_q;
    logic [LANES-1:0]             misal;
    logic [LANES/2-1:0]           same_blk;
    logic [LANES-1:0]             issued;
    logic [LANES-1:0]             wr_en;
    logic [LANES-1:0][ELEM_W-1:0] wr_data;
    logic [FC_W-1:0]              issue_cnt;

    // flag lanes whose address is not element aligned
    always_comb begin
        for (int i = 0; i < LANES; i++)
            misal[i] = |elem_addr[i][EB_W-1:0];
    end

    gpc_pair_match #(.LANES(LANES), .BLK_W(BLK_W)) u_match (
        .blk      (blk_q),
        .same_blk (same_blk)
    );

    gpc_flow_pick #(.LANES(LANES), .NPORT(NPORT), .ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_pick (
        .pend     (busy ? pend_q : '0),
        .same_blk (same_blk),
        .blk      (blk_q),
        .f_valid  (rd_valid),
        .f_mask   (rd_tag),
        .f_addr   (rd_addr)
    );

    gpc_lane_write #(.LANES(LANES), .NPORT(NPORT), .ELEM_W(ELEM_W),
                     .WORDS(WORDS), .WSEL_W(WSEL_W)) u_write (
        .wsel      (wsel_q),
        .rsp_valid (rsp_valid),
        .rsp_tag   (rsp_tag),
        .rsp_data  (rsp_data),
        .wr_en     (wr_en),
        .wr_data   (wr_data)
    );

    // gather lanes issued this cycle and count the reads
    always_comb begin
        issued    = '0;
        issue_cnt = '0;
        for (int p = 0; p < NPORT; p++) begin
            if (rd_valid[p]) begin
                issued    = issued | rd_tag[p];
                issue_cnt = issue_cnt + FC_W'(1);
            end
        end
    end

    // gather state: accept, issue, collect, complete
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy         <= 1'b0;
            done         <= 1'b0;
            misalign_err <= 1'b0;
            flow_count   <= '0;
            pend_q       <= '0;
            wait_q       <= '0;
            dest_q       <= '0;
            blk_q        <= '0;
            wsel_q       <= '0;
        end else begin
            done <= 1'b0;
            if (start && !busy) begin
                for (int i = 0; i < LANES; i++) begin
                    blk_q[i]  <= elem_addr[i][ADDR_W-1:OFF_W];
                    wsel_q[i] <= elem_addr[i][OFF_W-1:EB_W];
                end
                pend_q       <= lane_en & ~misal;
                wait_q       <= '0;
                dest_q       <= '0;
                flow_count   <= '0;
                misalign_err <= |(lane_en & misal);
                busy         <= 1'b1;
            end else if (busy) begin
                pend_q     <= pend_q & ~issued;
                wait_q     <= (wait_q | issued) & ~wr_en;
                flow_count <= flow_count + issue_cnt;
                for (int i = 0; i < LANES; i++)
                    if (wr_en[i]) dest_q[i] <= wr_data[i];
                if (pend_q == '0 && wait_q == '0) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end
            end
        end
    end

    assign dest = dest_q;
endmodule

// File: rtl/gpc_checker.sv
// Module: protocol checks on the combiner's ports, bound to every instance.
// Assumes the synchronous active-low reset of the top.
module gpc_checker #(
    parameter int LANES  = 8,
    parameter int NPORT  = 2,
    parameter int ADDR_W = 64,
    parameter int FC_W   = 4
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         busy,
    input logic                         done,
    input logic [FC_W-1:0]              flow_count,
    input logic [NPORT-1:0]             rd_valid,
    input logic [NPORT-1:0][ADDR_W-1:0] rd_addr,
    input logic [NPORT-1:0][LANES-1:0]  rd_tag
);
    // a pulse lasts one cycle
    assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // done ends the busy period
    assert_done_ends_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy)));

    // no reads outside a gather
    assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (rd_valid == '0));

    // upper port only alongside the lower
    assert_port_order_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid[1] |-> rd_valid[0]);

    // read counter never exceeds lane count
    assert_count_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
        flow_count <= FC_W'(LANES));

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        // block aligned addresses
        assert_blk_align_R9: assert property (@(posedge clk) disable iff (!rst_n)
            rd_valid[p] |-> (rd_addr[p][6:0] == 7'd0));
        // a read serves one or two lanes
        assert_tag_size_R1: assert property (@(posedge clk) disable iff (!rst_n)
            rd_valid[p] |-> ($countones(rd_tag[p]) inside {1, 2}));
    end
endmodule

bind gather_pair_combiner gpc_checker #(
    .LANES(LANES), .NPORT(NPORT), .ADDR_W(ADDR_W), .FC_W(FC_W)
) u_gpc_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy       (busy),
    .done       (done),
    .flow_count (flow_count),
    .rd_valid   (rd_valid),
    .rd_addr    (rd_addr),
    .rd_tag     (rd_tag)
);

// File: tb/test_gather_pair_combiner.sv
// Bench: directed corners plus seeded random gathers against a
// two-cycle memory model; expected data and read counts come from functions.
module test_gather_pair_combiner;
    localparam int LANES = 8;
    localparam int NPORT = 2;
    localparam int WORDS = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [LANES-1:0][63:0] elem_addr = '0;
    logic [LANES-1:0] lane_en = '0;
    logic busy, done, misalign_err;
    logic [3:0] flow_count;
    logic [LANES*64-1:0] dest;
    logic [NPORT-1:0] rd_valid;
    logic [NPORT-1:0][63:0] rd_addr;
    logic [NPORT-1:0][LANES-1:0] rd_tag;
    logic [NPORT-1:0] rsp_valid;
    logic [NPORT-1:0][LANES-1:0] rsp_tag;
    logic [NPORT-1:0][WORDS-1:0][63:0] rsp_data;

    logic [NPORT-1:0] s1_v;
    logic [NPORT-1:0][63:0] s1_a, rsp_a;
    logic [NPORT-1:0][LANES-1:0] s1_t;

    int total = 0;
    int bad = 0;
    int seen_reads = 0;
    int last_cycles = 0;

    always #5 clk = ~clk;

    gather_pair_combiner i_gather_pair_combiner (
        .clk(clk), .rst_n(rst_n), .start(start), .elem_addr(elem_addr),
        .lane_en(lane_en), .busy(busy), .done(done), .misalign_err(misalign_err),
        .flow_count(flow_count), .dest(dest), .rd_valid(rd_valid),
        .rd_addr(rd_addr), .rd_tag(rd_tag), .rsp_valid(rsp_valid),
        .rsp_tag(rsp_tag), .rsp_data(rsp_data)
    );

    function automatic logic [63:0] mem_word(input logic [63:0] a);
        return {a[31:0] ^ 32'hC3A5_5A3C, a[31:0]};
    endfunction

    // memory model: two register stages, then the block contents
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_v <= '0; s1_a <= '0; s1_t <= '0;
            rsp_valid <= '0; rsp_a <= '0; rsp_tag <= '0;
        end else begin
            s1_v <= rd_valid; s1_a <= rd_addr; s1_t <= rd_tag;
            rsp_valid <= s1_v; rsp_a <= s1_a; rsp_tag <= s1_t;
        end
    end

    always_comb begin
        for (int p = 0; p < NPORT; p++)
            for (int w = 0; w < WORDS; w++)
                rsp_data[p][w] = mem_word(rsp_a[p] + 64'(w * 8));
    end

    always @(negedge clk) begin
        for (int p = 0; p < NPORT; p++)
            if (rst_n && rd_valid[p]) seen_reads++;
    end

    function automatic logic usable(input logic [63:0] a, input logic en);
        return en && (a[2:0] == 3'b000);
    endfunction

    function automatic int exp_flows(input logic [LANES-1:0][63:0] a,
                                     input logic [LANES-1:0] en);
        int n = 0;
        for (int k = 0; k < LANES / 2; k++) begin
            logic u0 = usable(a[2*k], en[2*k]);
            logic u1 = usable(a[2*k+1], en[2*k+1]);
            if (u0 && u1 && a[2*k][63:7] == a[2*k+1][63:7]) n += 1;
            else n += int'(u0) + int'(u1);
        end
        return n;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // one gather; optionally pokes a second start while busy
    task automatic run(input logic [LANES-1:0][63:0] a, input logic [LANES-1:0] en,
                       input bit poke, input string tag);
        int cyc = 0;
        logic exp_err = 1'b0;
        @(negedge clk);
        elem_addr = a; lane_en = en; start = 1'b1; seen_reads = 0;
        @(negedge clk);
        start = 1'b0;
        check(busy == 1'b1, "R7", {tag, " busy after start"}, 64'(busy), 64'd1);
        if (poke) begin
            elem_addr = ~a; lane_en = ~en; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            cyc++;
        end
        while (!done && cyc < 100) begin
            @(negedge clk);
            cyc++;
        end
        last_cycles = cyc;
        check(done == 1'b1, "R6", {tag, " done seen"}, 64'(done), 64'd1);
        check(busy == 1'b0, "R7", {tag, " busy low at done"}, 64'(busy), 64'd0);
        for (int i = 0; i < LANES; i++) begin
            logic [63:0] e = usable(a[i], en[i]) ? mem_word(a[i]) : 64'd0;
            if (en[i] && a[i][2:0] != 3'b000) exp_err = 1'b1;
            check(dest[i*64 +: 64] == e, "R4", {tag, $sformatf(" lane %0d data (R3,R5)", i)},
                  dest[i*64 +: 64], e);
        end
        check(int'(flow_count) == exp_flows(a, en), "R8",
              {tag, " read count (R1,R2,R3)"}, 64'(flow_count), 64'(exp_flows(a, en)));
        check(seen_reads == exp_flows(a, en), "R1", {tag, " reads seen on ports"},
              64'(seen_reads), 64'(exp_flows(a, en)));
        check(misalign_err == exp_err, "R5", {tag, " error flag"},
              64'(misalign_err), 64'(exp_err));
        @(negedge clk);
        check(done == 1'b0, "R6", {tag, " done one cycle"}, 64'(done), 64'd0);
        check(int'(flow_count) == exp_flows(a, en), "R6", {tag, " count holds"},
              64'(flow_count), 64'(exp_flows(a, en)));
    endtask

    initial begin
        logic [LANES-1:0][63:0] a;
        logic [LANES-1:0] en;
        int t_comb, t_split;
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        check(busy == 1'b0 && done == 1'b0, "R10", "reset busy/done", 64'({busy, done}), 64'd0);
        check(flow_count == 4'd0 && misalign_err == 1'b0, "R10", "reset count/err",
              64'({flow_count, misalign_err}), 64'd0);
        check(dest == '0, "R10", "reset dest", dest[63:0], 64'd0);

        // R1, R4: every pair shares a block, word offsets at both ends
        for (int k = 0; k < 4; k++) begin
            a[2*k]   = 64'h0000_1000_0000_0000 + 64'(k * 256);
            a[2*k+1] = a[2*k] + 64'd120;
        end
        run(a, 8'hFF, 1'b0, "R1 all pairs combined");
        t_comb = last_cycles;

        // R2: every pair split
        for (int i = 0; i < LANES; i++) a[i] = 64'h0000_2000_0000_0000 + 64'(i * 128 + 8);
        run(a, 8'hFF, 1'b0, "R2 all pairs split");
        t_split = last_cycles;
        check(t_comb < t_split, "R2", "combined finishes sooner", 64'(t_comb), 64'(t_split));

        // R3: single lanes of pairs and a fully disabled gather
        run(a, 8'b0110_1001, 1'b0, "R3 one lane per pair");
        run(a, 8'h00, 1'b0, "R3 nothing enabled");

        // R5: misaligned lanes
        a[3] = a[3] + 64'd4; a[6] = a[6] + 64'd1;
        run(a, 8'hFF, 1'b0, "R5 misaligned");

        // R7: start while busy ignored
        for (int k = 0; k < 4; k++) begin
            a[2*k]   = 64'h0000_3000_0000_0040 + 64'(k * 512);
            a[2*k+1] = a[2*k] + 64'd16;
        end
        run(a, 8'hFF, 1'b1, "R7 start ignored");

        // random gathers
        for (int n = 0; n < 150; n++) begin
            for (int k = 0; k < 4; k++) begin
                logic [63:0] b0 = {$urandom, $urandom};
                logic [63:0] b1 = ($urandom_range(0, 1) == 0) ? b0 : {$urandom, $urandom};
                a[2*k]   = {b0[63:7], 4'($urandom), 3'b000};
                a[2*k+1] = {b1[63:7], 4'($urandom), 3'b000};
                if ($urandom_range(0, 15) == 0) a[2*k] = a[2*k] | 64'd2;
            end
            en = 8'($urandom);
            run(a, en, ($urandom_range(0, 3) == 0), "random");
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog run did not finish actual=hang expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule